// File: doc/BRIEF.md
# Cascaded Coordinate Lookup Pipeline

This block converts one chamber track segment per clock into global detector coordinates through a chain of three lookup tables. The first table is addressed by the segment's pattern number, quality, strip position and left/right flag. It returns a local phi and a local bend angle. Two second-level tables are then addressed in parallel. Their addresses are formed from slices of the first-level result together with the chamber and wire-group identifiers. Those identifiers are delayed so that they arrive at the same cycle as the first-level data.

The eta table returns a global bend and a global eta. The phi table returns a global phi and a second phi value meant for the barrel interface. All three tables are synchronous RAMs inside the block, and a host port loads them while the pipeline is stopped.

Field widths are parameters. The defaults are kept small so that the tables stay small. Production widths are set by overriding them: pattern 4, quality 4, strip 8, chamber 4, wire group 7, wire-group slice 5, local phi 10 and local bend 6.

Top module: `coord_lookup_pipe`

## Requirements
- R1: The local table address is {pattern, quality, strip, lr}, with the MSB first. In its entry, the low LPHI_W bits are the local phi and the next LBEND_W bits are the local bend.
- R2: The eta table address is {chamber, wiregroup, local bend, top two bits of local phi}. In its entry, bits [4:0] are the global bend and bits [11:5] are the global eta.
- R3: The phi table address is {chamber, top WGS_W bits of wiregroup, local phi}. In its entry, bits [11:0] are the global phi and bits [23:12] are the barrel phi.
- R4: A segment is accepted at a rising edge where in_valid and run_en are both 1. Its result and out_valid are visible after the third rising edge, counting the accepting edge. No result appears before that.
- R5: A segment offered while run_en is 0 is dropped and never produces out_valid.
- R6: A host write made while run_en is 1 leaves every table unchanged.
- R7: wr_sel values 0, 1 and 2 select the local, eta and phi table. A write with wr_sel 3 changes no table. A write with run_en 0 and a valid select replaces the entry.
- R8: While out_valid is 0, the coordinate outputs keep their previous values.
- R9: Reset drives out_valid and every coordinate output to zero.
- R10: Segments may be accepted on consecutive cycles. Each result uses its own segment's chamber and wire-group identifiers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline and table clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Pipeline enable; blocks host writes when high |
| in_valid | input | 1 | Segment present |
| in_pattern | input | PAT_W | Pattern number |
| in_quality | input | QUAL_W | Segment quality |
| in_strip | input | STRIP_W | Strip position |
| in_lr | input | 1 | Left/right half-strip flag |
| in_chamber | input | CHAM_W | Chamber identifier |
| in_wiregroup | input | WG_W | Wire-group identifier |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Table select: 0 local, 1 eta, 2 phi, 3 none |
| wr_addr | input | WR_AW | Host write address |
| wr_data | input | 24 | Host write data, low bits used per table |
| out_valid | output | 1 | Result valid |
| out_gbend | output | 5 | Global bend |
| out_geta | output | 7 | Global eta |
| out_gphi | output | 12 | Global phi |
| out_bphi | output | 12 | Barrel-interface phi |

## Verification
Each result is due three rising edges after the edge that accepts its segment. The edges are the local table read, the two parallel second-level reads and the output register. The bench drives inputs on falling edges and samples on the falling edge that follows the third rising edge. One falling edge earlier, it also confirms that out_valid is still low. In streaming runs, the check for segment k is made at the same falling edge that drives segment k+3, so a shift of a single cycle in the chamber or wire-group delay shows up as a mismatch. Dropped segments and blocked writes are observed over more than the full three-cycle window before any later stimulus.

// File: rtl/coord_lut_pkg.sv
package coord_lut_pkg;

    localparam int GBEND_W = 5;
    localparam int GETA_W  = 7;
    localparam int GPHI_W  = 12;
    localparam int BPHI_W  = 12;

    localparam int ETA_DW  = GBEND_W + GETA_W;
    localparam int PHI_DW  = GPHI_W + BPHI_W;
    localparam int HOST_DW = PHI_DW;

    localparam int PHI_TOP_W = 2;   // local phi MSBs used in eta address

    localparam int PIPE_LAT = 3;

    typedef enum logic [1:0] {
        TBL_LOCAL = 2'd0,
        TBL_ETA   = 2'd1,
        TBL_PHI   = 2'd2,
        TBL_NONE  = 2'd3
    } tbl_sel_e;

    typedef struct packed {
        logic [BPHI_W-1:0]  bphi;
        logic [GPHI_W-1:0]  gphi;
        logic [GETA_W-1:0]  geta;
        logic [GBEND_W-1:0] gbend;
    } glob_coord_t;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/clp_table_ram.sv
module clp_table_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/clp_local_stage.sv
module clp_local_stage #(
    parameter int PAT_W   = 2,
    parameter int QUAL_W  = 2,
    parameter int STRIP_W = 5,
    parameter int CHAM_W  = 2,
    parameter int WG_W    = 2,
    parameter int LPHI_W  = 6,
    parameter int LBEND_W = 4,
    localparam int AW     = PAT_W + QUAL_W + STRIP_W + 1,
    localparam int DW     = LPHI_W + LBEND_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic [PAT_W-1:0]   pattern,
    input  logic [QUAL_W-1:0]  quality,
    input  logic [STRIP_W-1:0] strip,
    input  logic               lr,
    input  logic [CHAM_W-1:0]  chamber,
    input  logic [WG_W-1:0]    wiregroup,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [DW-1:0]      wdata,
    output logic [LPHI_W-1:0]  lphi,
    output logic [LBEND_W-1:0] lbend,
    output logic [CHAM_W-1:0]  chamber_d,
    output logic [WG_W-1:0]    wiregroup_d,
    output logic               valid_d
);
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata;

    assign raddr = {pattern, quality, strip, lr};

    clp_table_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign lphi  = rdata[LPHI_W-1:0];
    assign lbend = rdata[DW-1:LPHI_W];

    // side fields follow the one-cycle table read
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_d     <= 1'b0;
            chamber_d   <= '0;
            wiregroup_d <= '0;
        end else begin
            valid_d     <= accept;
            chamber_d   <= chamber;
            wiregroup_d <= wiregroup;
        end
    end
endmodule

// File: rtl/clp_global_stage.sv
module clp_global_stage
    import coord_lut_pkg::*;
#(
    parameter int CHAM_W  = 2,
    parameter int WG_W    = 2,
    parameter int WGS_W   = 1,
    parameter int LPHI_W  = 6,
    parameter int LBEND_W = 4,
    localparam int ETA_AW = CHAM_W + WG_W + LBEND_W + PHI_TOP_W,
    localparam int PHI_AW = CHAM_W + WGS_W + LPHI_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_in,
    input  logic [LPHI_W-1:0]  lphi,
    input  logic [LBEND_W-1:0] lbend,
    input  logic [CHAM_W-1:0]  chamber,
    input  logic [WG_W-1:0]    wiregroup,
    input  logic               eta_we,
    input  logic [ETA_AW-1:0]  eta_waddr,
    input  logic [ETA_DW-1:0]  eta_wdata,
    input  logic               phi_we,
    input  logic [PHI_AW-1:0]  phi_waddr,
    input  logic [PHI_DW-1:0]  phi_wdata,
    output glob_coord_t        coord,
    output logic               valid_out
);
    logic [ETA_AW-1:0] eta_raddr;
    logic [PHI_AW-1:0] phi_raddr;
    logic [ETA_DW-1:0] eta_word;
    logic [PHI_DW-1:0] phi_word;

    assign eta_raddr = {chamber, wiregroup, lbend,
                        lphi[LPHI_W-1 -: PHI_TOP_W]};
    assign phi_raddr = {chamber, wiregroup[WG_W-1 -: WGS_W], lphi};

    clp_table_ram #(.AW(ETA_AW), .DW(ETA_DW)) u_eta_ram (
        .clk   (clk),
        .we    (eta_we),
        .waddr (eta_waddr),
        .wdata (eta_wdata),
        .raddr (eta_raddr),
        .rdata (eta_word)
    );

    clp_table_ram #(.AW(PHI_AW), .DW(PHI_DW)) u_phi_ram (
        .clk   (clk),
        .we    (phi_we),
        .waddr (phi_waddr),
        .wdata (phi_wdata),
        .raddr (phi_raddr),
        .rdata (phi_word)
    );

    always_comb begin
        coord.gbend = eta_word[GBEND_W-1:0];
        coord.geta  = eta_word[ETA_DW-1:GBEND_W];
        coord.gphi  = phi_word[GPHI_W-1:0];
        coord.bphi  = phi_word[PHI_DW-1:GPHI_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out <= 1'b0;
        end else begin
            valid_out <= valid_in;
        end
    end
endmodule

// File: rtl/coord_lookup_pipe.sv
module coord_lookup_pipe
    import coord_lut_pkg::*;
#(
    parameter int PAT_W   = 2,
    parameter int QUAL_W  = 2,
    parameter int STRIP_W = 5,
    parameter int CHAM_W  = 2,
    parameter int WG_W    = 2,
    parameter int WGS_W   = 1,
    parameter int LPHI_W  = 6,
    parameter int LBEND_W = 4,
    localparam int LOC_AW = PAT_W + QUAL_W + STRIP_W + 1,
    localparam int LOC_DW = LPHI_W + LBEND_W,
    localparam int ETA_AW = CHAM_W + WG_W + LBEND_W + PHI_TOP_W,
    localparam int PHI_AW = CHAM_W + WGS_W + LPHI_W,
    localparam int WR_AW  = max_of3(LOC_AW, ETA_AW, PHI_AW)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_en,
    input  logic               in_valid,
    input  logic [PAT_W-1:0]   in_pattern,
    input  logic [QUAL_W-1:0]  in_quality,
    input  logic [STRIP_W-1:0] in_strip,
    input  logic               in_lr,
    input  logic [CHAM_W-1:0]  in_chamber,
    input  logic [WG_W-1:0]    in_wiregroup,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [WR_AW-1:0]   wr_addr,
    input  logic [HOST_DW-1:0] wr_data,
    output logic               out_valid,
    output logic [GBEND_W-1:0] out_gbend,
    output logic [GETA_W-1:0]  out_geta,
    output logic [GPHI_W-1:0]  out_gphi,
    output logic [BPHI_W-1:0]  out_bphi
);
    logic [2:0]         tbl_we;
    logic               host_ok;
    logic               accept;
    logic [LPHI_W-1:0]  s1_lphi;
    logic [LBEND_W-1:0] s1_lbend;
    logic [CHAM_W-1:0]  s1_chamber;
    logic [WG_W-1:0]    s1_wiregroup;
    logic               s1_valid;
    glob_coord_t        s2_coord;
    logic               s2_valid;
    glob_coord_t        out_coord;

    assign accept  = in_valid & run_en;
    assign host_ok = wr_en & ~run_en;

    // one write enable per table, from the host select
    for (genvar t = 0; t < 3; t++) begin : g_we
        assign tbl_we[t] = host_ok && (wr_sel == 2'(t));
    end

    clp_local_stage #(
        .PAT_W(PAT_W), .QUAL_W(QUAL_W), .STRIP_W(STRIP_W),
        .CHAM_W(CHAM_W), .WG_W(WG_W), .LPHI_W(LPHI_W), .LBEND_W(LBEND_W)
    ) u_local (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .pattern     (in_pattern),
        .quality     (in_quality),
        .strip       (in_strip),
        .lr          (in_lr),
        .chamber     (in_chamber),
        .wiregroup   (in_wiregroup),
        .we          (tbl_we[TBL_LOCAL]),
        .waddr       (wr_addr[LOC_AW-1:0]),
        .wdata       (wr_data[LOC_DW-1:0]),
        .lphi        (s1_lphi),
        .lbend       (s1_lbend),
        .chamber_d   (s1_chamber),
        .wiregroup_d (s1_wiregroup),
        .valid_d     (s1_valid)
    );

    clp_global_stage #(
        .CHAM_W(CHAM_W), .WG_W(WG_W), .WGS_W(WGS_W),
        .LPHI_W(LPHI_W), .LBEND_W(LBEND_W)
    ) u_global (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (s1_valid),
        .lphi      (s1_lphi),
        .lbend     (s1_lbend),
        .chamber   (s1_chamber),
        .wiregroup (s1_wiregroup),
        .eta_we    (tbl_we[TBL_ETA]),
        .eta_waddr (wr_addr[ETA_AW-1:0]),
        .eta_wdata (wr_data[ETA_DW-1:0]),
        .phi_we    (tbl_we[TBL_PHI]),
        .phi_waddr (wr_addr[PHI_AW-1:0]),
        .phi_wdata (wr_data[PHI_DW-1:0]),
        .coord     (s2_coord),
        .valid_out (s2_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_coord <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) begin
                out_coord <= s2_coord;
            end
        end
    end

    assign out_gbend = out_coord.gbend;
    assign out_geta  = out_coord.geta;
    assign out_gphi  = out_coord.gphi;
    assign out_bphi  = out_coord.bphi;
endmodule

// File: rtl/clp_checker.sv
module clp_checker (
    input logic        clk,
    input logic        rst,
    input logic        run_en,
    input logic        in_valid,
    input logic [2:0]  tbl_we,
    input logic        out_valid,
    input logic [35:0] out_all
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R4 / R5: result exactly three edges after acceptance, never otherwise
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid && run_en, 3)));

    // R6: no table written while the pipeline runs
    p_run_blocks_write_r6: assert property (@(posedge clk) disable iff (rst)
        run_en |-> (tbl_we == 3'b000));

    // R7: at most one table written per cycle
    p_single_table_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tbl_we));

    // R8: outputs hold while no result is flagged
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_all));

    // R9: reset clears the result
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!out_valid && (out_all == 36'd0)));
endmodule

bind coord_lookup_pipe clp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .in_valid  (in_valid),
    .tbl_we    (tbl_we),
    .out_valid (out_valid),
    .out_all   ({out_bphi, out_gphi, out_geta, out_gbend})
);

// File: tb/sim_coord_lookup_pipe.sv
module sim_coord_lookup_pipe;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_pattern = '0;
    logic [1:0]  in_quality = '0;
    logic [4:0]  in_strip = '0;
    logic        in_lr = 1'b0;
    logic [1:0]  in_chamber = '0;
    logic [1:0]  in_wiregroup = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [9:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        out_valid;
    logic [4:0]  out_gbend;
    logic [6:0]  out_geta;
    logic [11:0] out_gphi;
    logic [11:0] out_bphi;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench copies of the table contents
    logic [9:0]  m_loc [1024];
    logic [11:0] m_eta [1024];
    logic [23:0] m_phi [512];

    always #2.5 clk = ~clk;

    coord_lookup_pipe u0 (
        .clk(clk), .rst(rst), .run_en(run_en), .in_valid(in_valid),
        .in_pattern(in_pattern), .in_quality(in_quality), .in_strip(in_strip),
        .in_lr(in_lr), .in_chamber(in_chamber), .in_wiregroup(in_wiregroup),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_gbend(out_gbend), .out_geta(out_geta),
        .out_gphi(out_gphi), .out_bphi(out_bphi)
    );

    task automatic check(input string req, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // segment as {pat, qual, strip, lr, cham, wg} = 14 bits
    function automatic logic [13:0] seg_of(input int i);
        return 14'((i * 2713 + 91) ^ (i << 5));
    endfunction

    // expected {bphi, gphi, geta, gbend} per R1..R3
    function automatic logic [35:0] expect_of(input logic [13:0] s);
        logic [9:0]  a1;
        logic [9:0]  w1;
        logic [5:0]  lphi;
        logic [3:0]  lbend;
        logic [1:0]  ch;
        logic [1:0]  wg;
        logic [9:0]  a2;
        logic [8:0]  a3;
        logic [11:0] e;
        logic [23:0] p;
        a1    = s[13:4];
        ch    = s[3:2];
        wg    = s[1:0];
        w1    = m_loc[a1];
        lphi  = w1[5:0];
        lbend = w1[9:6];
        a2    = {ch, wg, lbend, lphi[5:4]};
        a3    = {ch, wg[1], lphi};
        e     = m_eta[a2];
        p     = m_phi[a3];
        return {p[23:12], p[11:0], e[11:5], e[4:0]};
    endfunction

    function automatic logic [35:0] outs();
        return {out_bphi, out_gphi, out_geta, out_gbend};
    endfunction

    task automatic drive_seg(input logic [13:0] s, input logic v);
        in_valid     = v;
        in_pattern   = s[13:12];
        in_quality   = s[11:10];
        in_strip     = s[9:5];
        in_lr        = s[4];
        in_chamber   = s[3:2];
        in_wiregroup = s[1:0];
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [9:0] a,
                              input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // single segment: valid low one negedge early, result at third
    task automatic run_one(input logic [13:0] s, input string req);
        @(negedge clk);
        drive_seg(s, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R4", "not early", {35'd0, out_valid}, 36'd0);
        @(negedge clk);
        check(req, "valid", {35'd0, out_valid}, 36'd1);
        check(req, "coords", outs(), expect_of(s));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9", "valid after reset", {35'd0, out_valid}, 36'd0);
        check("R9", "coords after reset", outs(), 36'd0);
    endtask

    task automatic t_load();
        run_en = 1'b0;
        for (int a = 0; a < 1024; a++) begin
            m_loc[a] = 10'((a * 397 + 13) ^ (a >> 2));
            host_write(2'd0, 10'(a), 24'(m_loc[a]));
        end
        for (int a = 0; a < 1024; a++) begin
            m_eta[a] = 12'((a * 1237 + 301) ^ (a << 3));
            host_write(2'd1, 10'(a), 24'(m_eta[a]));
        end
        for (int a = 0; a < 512; a++) begin
            m_phi[a] = 24'((a * 40503 + 7777) ^ (a << 13));
            host_write(2'd2, 10'(a), m_phi[a]);
        end
        @(negedge clk);
        run_en = 1'b1;
    endtask

    task automatic t_single();
        run_one(seg_of(1), "R1");
        run_one(14'h3FFF, "R2");
        run_one(14'h0000, "R3");
        run_one(seg_of(77), "R3");
    endtask

    // back-to-back: segment k checked at the negedge that drives k+3
    task automatic t_stream();
        for (int j = 0; j < 43; j++) begin
            @(negedge clk);
            if (j >= 3) begin
                check("R10", "stream valid", {35'd0, out_valid}, 36'd1);
                check("R10", "stream coords", outs(), expect_of(seg_of(j + 97)));
            end
            if (j < 40) drive_seg(seg_of(j + 100), 1'b1);
            else        in_valid = 1'b0;
        end
    endtask

    task automatic t_hold();
        logic [35:0] last;
        run_one(seg_of(5), "R8");
        last = outs();
        drive_seg(seg_of(900), 1'b0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R8", "hold valid", {35'd0, out_valid}, 36'd0);
            check("R8", "hold coords", outs(), last);
        end
    endtask

    task automatic t_drop();
        @(negedge clk);
        run_en = 1'b0;
        for (int k = 0; k < 8; k++) begin
            drive_seg(seg_of(k + 300), k < 4);
            @(negedge clk);
            check("R5", "dropped", {35'd0, out_valid}, 36'd0);
        end
        run_en = 1'b1;
    endtask

    task automatic t_blocked();
        logic [13:0] s;
        s = seg_of(11);
        run_en = 1'b1;
        host_write(2'd0, s[13:4], ~24'(m_loc[s[13:4]]));
        host_write(2'd2, 10'd0, ~m_phi[0]);
        run_one(s, "R6");
        run_one(14'h0000, "R6");
    endtask

    task automatic t_select();
        logic [13:0] s;
        s = seg_of(23);
        @(negedge clk);
        run_en = 1'b0;
        host_write(2'd3, s[13:4], ~24'(m_loc[s[13:4]]));
        @(negedge clk);
        run_en = 1'b1;
        run_one(s, "R7");
        @(negedge clk);
        run_en = 1'b0;
        m_loc[s[13:4]] = m_loc[s[13:4]] ^ 10'h2A5;
        host_write(2'd0, s[13:4], 24'(m_loc[s[13:4]]));
        begin
            logic [9:0] w1;
            logic [8:0] a3;
            w1 = m_loc[s[13:4]];
            a3 = {s[3:2], s[1], w1[5:0]};
            m_phi[a3] = m_phi[a3] ^ 24'hA5A5A5;
            host_write(2'd2, 10'(a3), m_phi[a3]);
        end
        @(negedge clk);
        run_en = 1'b1;
        run_one(s, "R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_single();
        t_stream();
        t_hold();
        t_drop();
        t_blocked();
        t_select();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule